// File: doc/BRIEF.md
# Next Instruction Address Unit

This block owns the program counter of a simple 32-bit in-order core and works out, every cycle, where the following instruction comes from. Each cycle it takes the raw major opcode and function code of the instruction now at the PC, along with these inputs:

- the two source register values;
- the 16-bit displacement;
- the 26-bit jump field;
- a register value for indirect jumps.

From these it classifies the instruction as plain sequential, branch-on-equal, branch-on-not-equal, absolute jump, jump-with-link or register jump. It then loads the matching address into the PC.

For jump-with-link it also presents the return address together with a one-cycle write strobe meant for register 31. Instructions arrive through a plain `step` qualifier. The unit keeps no queue and never pushes back: a cycle with `step` high always consumes the instruction, and a cycle with `step` low leaves all state untouched.

Top module: `npc_unit`

## Requirements
- R1: A synchronous `rst` sampled high loads the PC with 0 at that clock edge. `link_we` stays low for as long as `rst` is high.
- R2: While `step` is low, the PC keeps its value across clock edges, whatever the other inputs carry.
- R3: When `step` is high and the instruction is none of the classes in R4 to R8, the PC becomes PC+4. This covers opcode 0 with any function code other than 8. The addition wraps modulo 2^32, so 0xFFFFFFFC steps to 0.
- R4: Opcode 4 (branch if equal) with `rs_val` equal to `rt_val` loads PC+4 plus the sign-extended displacement shifted left by two, modulo 2^32. With unequal operands it loads PC+4.
- R5: Opcode 5 (branch if not equal) takes the same target as R4 when `rs_val` differs from `rt_val`. With equal operands it loads PC+4.
- R6: Opcode 2 (jump) loads {PC+4[31:28], jfield, 2'b00}. The top four bits of the PC therefore always come from PC+4.
- R7: Opcode 3 (jump with link) loads the same target as R6. In the same cycle it raises `link_we` with `link_addr` equal to PC+4. `link_we` is low in every other cycle.
- R8: Opcode 0 with function code 8 (register jump) loads `ind_addr` into the PC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Current instruction is consumed this cycle |
| op | input | 6 | Major opcode of the current instruction |
| funct | input | 6 | Function code, meaningful for opcode 0 |
| rs_val | input | 32 | First compared register value |
| rt_val | input | 32 | Second compared register value |
| imm | input | 16 | Signed word displacement for branches |
| jfield | input | 26 | Word target field for absolute jumps |
| ind_addr | input | 32 | Target for a register jump |
| pc | output | 32 | Current program counter |
| link_addr | output | 32 | Return address (PC+4) |
| link_we | output | 1 | One-cycle strobe to write `link_addr` into register 31 |

## Verification
The assertions assume three things about the inputs:

- `rst` is held high across the first clock edges.
- `op`, `funct` and both operand values are known whenever `step` is high.
- Each input stays constant from one sampling edge to the next.

The bench drives every input on the falling clock edge, only with defined values taken from a deterministic generator, and keeps reset asserted for two edges before the first instruction. The stimulus sweeps all 64 opcodes and all 64 function codes of opcode 0, with operands forced equal and unequal. It also places the PC at the top of the address space and at a region boundary, so that wrapping and region selection come from real arithmetic.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    FK_SEQ,
    FK_BEQ,
    FK_BNE,
    FK_JMP,
    FK_JAL,
    FK_JREG
  } flow_kind_e;

  localparam logic [5:0] OPC_SPECIAL = 6'd0;
  localparam logic [5:0] OPC_JMP     = 6'd2;
  localparam logic [5:0] OPC_JAL     = 6'd3;
  localparam logic [5:0] OPC_BEQ     = 6'd4;
  localparam logic [5:0] OPC_BNE     = 6'd5;
  localparam logic [5:0] FN_JREG     = 6'd8;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [5:0]  op,
  input  logic [5:0]  funct,
  output flow_kind_e  kind
);
  always_comb begin
    unique case (op)
      OPC_BEQ:     kind = FK_BEQ;
      OPC_BNE:     kind = FK_BNE;
      OPC_JMP:     kind = FK_JMP;
      OPC_JAL:     kind = FK_JAL;
      OPC_SPECIAL: kind = (funct == FN_JREG) ? FK_JREG : FK_SEQ;
      default:     kind = FK_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int AW   = 32,
  parameter int OFFW = 16,
  parameter int JFW  = 26
) (
  input  logic [AW-1:0]   cur_pc,
  input  logic [OFFW-1:0] imm,
  input  logic [JFW-1:0]  jfield,
  output logic [AW-1:0]   seq_addr,
  output logic [AW-1:0]   br_addr,
  output logic [AW-1:0]   jmp_addr
);
  localparam int SHW   = 2;
  localparam int EXTW  = AW - OFFW - SHW;
  localparam int REG_W = AW - JFW - SHW;

  logic [AW-1:0] disp;

  assign seq_addr = cur_pc + AW'(4);
  assign disp     = {{EXTW{imm[OFFW-1]}}, imm, {SHW{1'b0}}};
  assign br_addr  = seq_addr + disp;

  generate
    if (REG_W > 0) begin : g_region
      assign jmp_addr = {seq_addr[AW-1 -: REG_W], jfield, {SHW{1'b0}}};
    end else begin : g_flat
      assign jmp_addr = {jfield[AW-SHW-1:0], {SHW{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int AW = 32
) (
  input  flow_kind_e    kind,
  input  logic [AW-1:0] rs_val,
  input  logic [AW-1:0] rt_val,
  input  logic [AW-1:0] seq_addr,
  input  logic [AW-1:0] br_addr,
  input  logic [AW-1:0] jmp_addr,
  input  logic [AW-1:0] ind_addr,
  output logic [AW-1:0] next_addr
);
  logic same;
  assign same = (rs_val == rt_val);

  always_comb begin
    unique case (kind)
      FK_BEQ:          next_addr = same  ? br_addr : seq_addr;
      FK_BNE:          next_addr = !same ? br_addr : seq_addr;
      FK_JMP, FK_JAL:  next_addr = jmp_addr;
      FK_JREG:         next_addr = ind_addr;
      default:         next_addr = seq_addr;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            OFFW     = 16,
  parameter int            JFW      = 26,
  parameter logic [31:0]   RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic [5:0]      op,
  input  logic [5:0]      funct,
  input  logic [AW-1:0]   rs_val,
  input  logic [AW-1:0]   rt_val,
  input  logic [OFFW-1:0] imm,
  input  logic [JFW-1:0]  jfield,
  input  logic [AW-1:0]   ind_addr,
  output logic [AW-1:0]   pc,
  output logic [AW-1:0]   link_addr,
  output logic            link_we
);
  flow_kind_e    kind;
  logic [AW-1:0] pc_q, seq_a, br_a, jmp_a, nxt_a;

  npc_decode u_dec (
    .op    (op),
    .funct (funct),
    .kind  (kind)
  );

  npc_target #(.AW(AW), .OFFW(OFFW), .JFW(JFW)) u_tgt (
    .cur_pc   (pc_q),
    .imm      (imm),
    .jfield   (jfield),
    .seq_addr (seq_a),
    .br_addr  (br_a),
    .jmp_addr (jmp_a)
  );

  npc_select #(.AW(AW)) u_sel (
    .kind      (kind),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .seq_addr  (seq_a),
    .br_addr   (br_a),
    .jmp_addr  (jmp_a),
    .ind_addr  (ind_addr),
    .next_addr (nxt_a)
  );

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= RESET_PC[AW-1:0];
    else if (step) pc_q <= nxt_a;
  end

  assign pc        = pc_q;
  assign link_addr = seq_a;
  assign link_we   = step && !rst && (kind == FK_JAL);
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int AW  = 32,
  parameter int JFW = 26
) (
  input logic          clk,
  input logic          rst,
  input logic          step,
  input logic [5:0]    op,
  input logic [5:0]    funct,
  input logic [AW-1:0] rs_val,
  input logic [AW-1:0] rt_val,
  input logic [AW-1:0] ind_addr,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] link_addr,
  input logic          link_we
);
  localparam int RW = AW - JFW - 2;
  logic [AW-1:0] p4;
  logic          plain;
  assign p4    = pc + AW'(4);
  assign plain = !(op inside {6'd2, 6'd3, 6'd4, 6'd5}) && !(op == 6'd0 && funct == 6'd8);

  a_r1_no_link_in_reset: assert property (@(posedge clk) rst |-> !link_we);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> pc == $past(pc));
  a_r3_seq: assert property (@(posedge clk) disable iff (rst)
    step && plain |=> pc == $past(p4));
  a_r4_beq_miss: assert property (@(posedge clk) disable iff (rst)
    step && op == 6'd4 && rs_val != rt_val |=> pc == $past(p4));
  a_r5_bne_miss: assert property (@(posedge clk) disable iff (rst)
    step && op == 6'd5 && rs_val == rt_val |=> pc == $past(p4));
  a_r6_region: assert property (@(posedge clk) disable iff (rst)
    step && (op == 6'd2 || op == 6'd3) |=>
      pc[AW-1 -: RW] == $past(p4[AW-1 -: RW]) && pc[1:0] == 2'b00);
  a_r7_link_val: assert property (@(posedge clk) disable iff (rst)
    link_we |-> link_addr == p4 && step && op == 6'd3);
  a_r7_no_link: assert property (@(posedge clk) disable iff (rst)
    op != 6'd3 |-> !link_we);
  a_r8_jreg: assert property (@(posedge clk) disable iff (rst)
    step && op == 6'd0 && funct == 6'd8 |=> pc == $past(ind_addr));
endmodule

bind npc_unit npc_unit_chk #(.AW(AW), .JFW(JFW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .step      (step),
  .op        (op),
  .funct     (funct),
  .rs_val    (rs_val),
  .rt_val    (rt_val),
  .ind_addr  (ind_addr),
  .pc        (pc),
  .link_addr (link_addr),
  .link_we   (link_we)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0;
  logic [5:0]  op = '0, funct = '0;
  logic [31:0] rs_val = '0, rt_val = '0, ind_addr = '0;
  logic [15:0] imm = '0;
  logic [25:0] jfield = '0;
  logic [31:0] pc, link_addr;
  logic        link_we;

  int unsigned vecs = 0, errs = 0;
  logic [31:0] mpc = '0;
  logic [31:0] seed = 32'h1234_5678;
  bit          done = 0;

  always #10 clk = ~clk;

  npc_unit i_npc_unit (
    .clk(clk), .rst(rst), .step(step), .op(op), .funct(funct),
    .rs_val(rs_val), .rt_val(rt_val), .imm(imm), .jfield(jfield),
    .ind_addr(ind_addr), .pc(pc), .link_addr(link_addr), .link_we(link_we)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] model_next(logic [5:0] o, logic [5:0] f,
      logic [31:0] a, logic [31:0] b, logic [15:0] d, logic [25:0] jf,
      logic [31:0] ia, logic [31:0] cur);
    logic [31:0] nx = cur + 32'd4;
    logic [31:0] bt = nx + (32'(signed'(d)) * 4);
    case (o)
      6'd4:    return (a == b) ? bt : nx;
      6'd5:    return (a != b) ? bt : nx;
      6'd2,
      6'd3:    return {nx[31:28], jf, 2'b00};
      6'd0:    return (f == 6'd8) ? ia : nx;
      default: return nx;
    endcase
  endfunction

  function automatic string tag_of(logic [5:0] o, logic [5:0] f);
    case (o)
      6'd4: return "R4 beq";
      6'd5: return "R5 bne";
      6'd2: return "R6 jump";
      6'd3: return "R7 jal";
      6'd0: return (f == 6'd8) ? "R8 jreg" : "R3 seq";
      default: return "R3 seq";
    endcase
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic apply(bit st, logic [5:0] o, logic [5:0] f, logic [31:0] a,
      logic [31:0] b, logic [15:0] d, logic [25:0] jf, logic [31:0] ia);
    logic [31:0] exp_pc;
    step = st; op = o; funct = f; rs_val = a; rt_val = b;
    imm = d; jfield = jf; ind_addr = ia;
    #1;
    chk("R7 link_we", {31'd0, link_we}, {31'd0, st && o == 6'd3});
    if (st && o == 6'd3) chk("R7 link_addr", link_addr, mpc + 32'd4);
    exp_pc = st ? model_next(o, f, a, b, d, jf, ia, mpc) : mpc;
    @(negedge clk);
    chk(st ? tag_of(o, f) : "R2 hold", pc, exp_pc);
    mpc = exp_pc;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    step = 1'b1; op = 6'd3;
    #1 chk("R1 link_we in reset", {31'd0, link_we}, 32'd0);
    chk("R1 reset pc", pc, 32'd0);
    rst = 1'b0;
    mpc = 32'd0;
    // Backward branch from 0 wraps downward (R4)
    apply(1, 6'd4, 0, 32'd7, 32'd7, 16'hFFFE, 0, 0);
    // Top of space: step wraps to 0 (R3)
    apply(1, 6'd0, 6'd8, 0, 0, 0, 0, 32'hFFFF_FFFC);
    apply(1, 6'd9, 0, 0, 0, 0, 0, 0);
    // Region boundary: jump from 0x7FFFFFFC picks region 8 (R6)
    apply(1, 6'd0, 6'd8, 0, 0, 0, 0, 32'h7FFF_FFFC);
    apply(1, 6'd2, 0, 0, 0, 0, 26'h3FF_FFFF, 0);
    // Hold with every kind of request offered (R2)
    for (int o = 0; o < 6; o++)
      apply(0, 6'(o), 6'd8, 1, 1, 16'h0010, 26'h155, 32'h40);
    // Full opcode sweep, equal and unequal operands
    for (int o = 0; o < 64; o++)
      for (int k = 0; k < 4; k++) begin
        logic [31:0] a = rnd();
        logic [31:0] b = k[0] ? a : rnd();
        apply(1, 6'(o), (k < 2) ? 6'd8 : rnd() % 64, a, b,
              rnd() % 65536, rnd() % (1 << 26), rnd() & 32'hFFFF_FFFC);
      end
    // Function-code sweep under opcode 0 (R3, R8)
    for (int f = 0; f < 64; f++)
      apply(1, 6'd0, 6'(f), 0, 0, 0, 0, rnd() & 32'hFFFF_FFFC);
    // Reset mid-run overrides a jump (R1)
    step = 1'b1; op = 6'd2; jfield = 26'h2AA_AAAA; rst = 1'b1;
    #1 chk("R1 link_we in reset", {31'd0, link_we}, 32'd0);
    @(negedge clk);
    chk("R1 reset pc", pc, 32'd0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule